// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a slave on a two-wire serial bus (SCL clock, SDA data) that fronts a 256-byte memory. A system clock samples both bus lines. Each line passes through a two-flop synchronizer and a short majority filter. Edge logic then finds START and STOP conditions and the SCL edges that carry data. The slave recognises its own device address, takes a word address and up to eight data bytes per write, and serves current-address, random and sequential reads.

Written bytes first collect in an eight-entry page buffer. Each entry has its own valid flag. A STOP ends the write. At that point an internally timed cycle starts, lasting `WR_CYCLES` system clocks. During that cycle the slave does not acknowledge, so a host can poll until it answers again. When the cycle ends, only the flagged bytes are copied into the array. A write-protect input stops any array update. SDA is open-drain: the block only pulls the line low or lets it float.

Top module: `eeprom_2w_slave`

## Requirements
- R1: The first byte after a START is taken MSB first. It must hold the pattern 1010 in bits 7..4, a copy of `strap_addr[2:0]` in bits 3..1, and a direction bit in bit 0 (1 = read, 0 = write). On a match, the slave pulls SDA low during the ninth clock.
- R2: If that first byte does not match, the slave gives no acknowledge and ignores every bus bit until the next START.
- R3: SDA falling while SCL is high is a START. SDA rising while SCL is high is a STOP. Data bits are sampled on SCL rising. The slave changes its SDA drive only while SCL is low.
- R4: `sda_pull_low` is the only SDA drive. It is 0 during reset and whenever the slave is not sending a 0 bit or an acknowledge.
- R5: A write is the device byte with direction 0, then a word address, then data bytes, each acknowledged. The timed cycle begins only at a STOP that follows at least one data byte. A START before that STOP discards the pending bytes.
- R6: During a write, each data byte advances only the low 3 bits of the word address. A ninth byte therefore overwrites the start of the same 8-byte page, and the last value written to an address wins.
- R7: For `WR_CYCLES` clocks after the STOP that starts a timed cycle, the device byte is not acknowledged. After that it is acknowledged again.
- R8: If `wr_protect` is high at the STOP, no byte reaches the array and no timed cycle begins.
- R9: The address counter holds the last accessed address plus one. A read with no preceding word address returns the byte at that counter.
- R10: A random read is a write header carrying the word address, then a repeated START, then the device byte with direction 1. It returns the byte at that word address.
- R11: In a read, each master acknowledge (SDA low on the ninth clock) moves to the next address across the whole array, wrapping from 255 to 0. A master non-acknowledge ends the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Sampled bus clock line |
| sda_in | input | 1 | Sampled bus data line (resolved wired-AND level) |
| strap_addr | input | 3 | Hard-wired device select bits |
| wr_protect | input | 1 | High blocks all array updates |
| sda_pull_low | output | 1 | High pulls SDA to 0, low releases it |

## Verification
A table of single-byte writes, each followed by a random read, covers data values that are all zeros, all ones and mixed, at addresses spread across the array. This separates a working data path from bit-order or addressing faults. Device bytes with a wrong strap field and with a wrong fixed pattern show whether the match compares every field. A ten-byte page write separates page wrap from linear increment. A read across address 255 separates whole-array wrap from page wrap. Polling straight after a STOP, a protected write and a write cut off by a repeated START each show whether the timed cycle starts only when it should.

// File: rtl/ee2w_pkg.sv
package ee2w_pkg;
    localparam int ADDR_W     = 8;
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int PAGE_W     = 3;
    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int ROW_W      = ADDR_W - PAGE_W;
    localparam logic [3:0] DEV_TAG = 4'b1010;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DEV,
        PH_WADR,
        PH_WDAT,
        PH_RDAT
    } phase_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_ev_t;

    function automatic logic dev_match(input logic [7:0] b, input logic [2:0] strap);
        return (b[7:4] == DEV_TAG) && (b[3:1] == strap);
    endfunction
endpackage

// File: rtl/ee2w_glitch_filter.sv
module ee2w_glitch_filter #(
    parameter int TAPS = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    localparam int HALF = TAPS / 2;

    logic [1:0]      sync_q;
    logic [TAPS-1:0] hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            hist_q <= '1;
            dout   <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], din};
            hist_q <= {hist_q[TAPS-2:0], sync_q[1]};
            dout   <= (int'($countones(hist_q)) > HALF);
        end
    end
endmodule

// File: rtl/ee2w_bus_fsm.sv
module ee2w_bus_fsm
    import ee2w_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic [2:0]        strap,
    input  logic              busy,
    input  logic [7:0]        rd_data,
    output logic [ADDR_W-1:0] addr_q,
    output logic              buf_clear,
    output logic              buf_we,
    output logic [7:0]        buf_data,
    output logic              commit_req,
    output logic              pull_low
);
    phase_t      phase_q;
    logic [3:0]  bitcnt_q;
    logic [7:0]  shift_q;
    logic [7:0]  tx_q;
    logic        rw_q;
    logic        macked_q;
    logic        live;

    assign live       = !busy && !ev.start && !ev.stop;
    assign buf_clear  = !busy && ev.start;
    assign buf_we     = live && ev.fall && (bitcnt_q == 4'd8) && (phase_q == PH_WDAT);
    assign buf_data   = shift_q;
    assign commit_req = !busy && ev.stop && (phase_q == PH_WDAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_IDLE;
            bitcnt_q <= '0;
            shift_q  <= '0;
            tx_q     <= '0;
            addr_q   <= '0;
            rw_q     <= 1'b0;
            macked_q <= 1'b0;
            pull_low <= 1'b0;
        end else if (busy) begin
            phase_q  <= PH_IDLE;
            bitcnt_q <= '0;
            pull_low <= 1'b0;
        end else if (ev.start) begin
            phase_q  <= PH_DEV;
            bitcnt_q <= '0;
            pull_low <= 1'b0;
        end else if (ev.stop) begin
            phase_q  <= PH_IDLE;
            bitcnt_q <= '0;
            pull_low <= 1'b0;
        end else if (phase_q != PH_IDLE) begin
            if (ev.rise) begin
                if (bitcnt_q < 4'd8) begin
                    shift_q  <= {shift_q[6:0], ev.sda};
                    bitcnt_q <= bitcnt_q + 4'd1;
                end else if (bitcnt_q == 4'd8) begin
                    macked_q <= !ev.sda;
                    bitcnt_q <= 4'd9;
                end
            end else if (ev.fall) begin
                if (bitcnt_q == 4'd8) begin
                    unique case (phase_q)
                        PH_DEV: begin
                            if (dev_match(shift_q, strap)) begin
                                pull_low <= 1'b1;
                                rw_q     <= shift_q[0];
                            end else begin
                                phase_q  <= PH_IDLE;
                                bitcnt_q <= '0;
                            end
                        end
                        PH_WADR: begin
                            pull_low <= 1'b1;
                            addr_q   <= shift_q;
                        end
                        PH_WDAT: begin
                            pull_low <= 1'b1;
                            addr_q   <= {addr_q[ADDR_W-1:PAGE_W], addr_q[PAGE_W-1:0] + 1'b1};
                        end
                        default: pull_low <= 1'b0;
                    endcase
                end else if (bitcnt_q == 4'd9) begin
                    bitcnt_q <= '0;
                    unique case (phase_q)
                        PH_DEV: begin
                            if (rw_q) begin
                                phase_q  <= PH_RDAT;
                                tx_q     <= rd_data;
                                addr_q   <= addr_q + 1'b1;
                                pull_low <= !rd_data[7];
                            end else begin
                                phase_q  <= PH_WADR;
                                pull_low <= 1'b0;
                            end
                        end
                        PH_RDAT: begin
                            if (macked_q) begin
                                tx_q     <= rd_data;
                                addr_q   <= addr_q + 1'b1;
                                pull_low <= !rd_data[7];
                            end else begin
                                phase_q  <= PH_IDLE;
                                pull_low <= 1'b0;
                            end
                        end
                        default: begin
                            phase_q  <= PH_WDAT;
                            pull_low <= 1'b0;
                        end
                    endcase
                end else if (phase_q == PH_RDAT) begin
                    tx_q     <= {tx_q[6:0], 1'b0};
                    pull_low <= !tx_q[6];
                end
            end
        end
    end
endmodule

// File: rtl/ee2w_store.sv
module ee2w_store
    import ee2w_pkg::*;
#(
    parameter int WR_CYCLES = 250000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    output logic [7:0]        rd_data,
    input  logic              buf_clear,
    input  logic              buf_we,
    input  logic [7:0]        buf_data,
    input  logic              commit_req,
    input  logic              wr_protect,
    output logic              busy
);
    localparam int CNT_W = $clog2(WR_CYCLES + 1);

    logic [7:0]            mem_q  [DEPTH];
    logic [7:0]            pbuf_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] pvalid_q;
    logic [ROW_W-1:0]      row_q;
    logic [CNT_W-1:0]      cnt_q;
    logic                  done;

    assign rd_data = mem_q[addr];
    assign done    = busy && (cnt_q == CNT_W'(WR_CYCLES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            pvalid_q <= '0;
            row_q    <= '0;
            cnt_q    <= '0;
            busy     <= 1'b0;
        end else if (busy) begin
            if (done) begin
                busy     <= 1'b0;
                pvalid_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else begin
            if (buf_clear) pvalid_q <= '0;
            if (buf_we) begin
                pvalid_q[addr[PAGE_W-1:0]] <= 1'b1;
                row_q <= addr[ADDR_W-1:PAGE_W];
            end
            if (commit_req) begin
                if (!wr_protect && (|pvalid_q)) begin
                    busy  <= 1'b1;
                    cnt_q <= '0;
                end else begin
                    pvalid_q <= '0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!busy && buf_we) pbuf_q[addr[PAGE_W-1:0]] <= buf_data;
    end

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_commit
        always_ff @(posedge clk) begin
            if (done && pvalid_q[g]) mem_q[{row_q, PAGE_W'(g)}] <= pbuf_q[g];
        end
    end
endmodule

// File: rtl/eeprom_2w_slave.sv
module eeprom_2w_slave
    import ee2w_pkg::*;
#(
    parameter int WR_CYCLES = 250000,
    parameter int FILT_TAPS = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic [2:0] strap_addr,
    input  logic       wr_protect,
    output logic       sda_pull_low
);
    logic [1:0]        raw_lines;
    logic [1:0]        filt_lines;
    logic              scl_f, sda_f, scl_q, sda_q;
    bus_ev_t           ev;
    logic [ADDR_W-1:0] cur_addr;
    logic [7:0]        rd_data, buf_data;
    logic              buf_clear, buf_we, commit_req, wr_busy;

    assign raw_lines = {scl_in, sda_in};

    for (genvar g = 0; g < 2; g++) begin : g_filt
        ee2w_glitch_filter #(.TAPS(FILT_TAPS)) u_filt (
            .clk (clk),
            .rst (rst),
            .din (raw_lines[g]),
            .dout(filt_lines[g])
        );
    end

    assign scl_f = filt_lines[1];
    assign sda_f = filt_lines[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    always_comb begin
        ev.start = scl_f && scl_q && sda_q && !sda_f;
        ev.stop  = scl_f && scl_q && !sda_q && sda_f;
        ev.rise  = scl_f && !scl_q;
        ev.fall  = !scl_f && scl_q;
        ev.sda   = sda_f;
    end

    ee2w_bus_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .strap     (strap_addr),
        .busy      (wr_busy),
        .rd_data   (rd_data),
        .addr_q    (cur_addr),
        .buf_clear (buf_clear),
        .buf_we    (buf_we),
        .buf_data  (buf_data),
        .commit_req(commit_req),
        .pull_low  (sda_pull_low)
    );

    ee2w_store #(.WR_CYCLES(WR_CYCLES)) u_store (
        .clk       (clk),
        .rst       (rst),
        .addr      (cur_addr),
        .rd_data   (rd_data),
        .buf_clear (buf_clear),
        .buf_we    (buf_we),
        .buf_data  (buf_data),
        .commit_req(commit_req),
        .wr_protect(wr_protect),
        .busy      (wr_busy)
    );
endmodule

// File: rtl/ee2w_checker.sv
module ee2w_checker (
    input logic clk,
    input logic rst,
    input logic busy,
    input logic pull,
    input logic scl_f,
    input logic commit_req,
    input logic wr_protect
);
    // R7: silent for the whole timed cycle
    a_r7_silent_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> !pull);

    // R3: the drive only changes after SCL has been seen low
    a_r3_drive_scl_low: assert property (@(posedge clk) disable iff (rst)
        !$stable(pull) |-> !$past(scl_f));

    // R8: a timed cycle never starts while protect is asserted
    a_r8_protect_no_cycle: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !$past(wr_protect));

    // R5: a timed cycle only follows a STOP ending a write
    a_r5_cycle_from_stop: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(commit_req));
endmodule

bind eeprom_2w_slave ee2w_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (wr_busy),
    .pull      (sda_pull_low),
    .scl_f     (scl_f),
    .commit_req(commit_req),
    .wr_protect(wr_protect)
);

// File: tb/eeprom_2w_slave_tb.sv
module eeprom_2w_slave_tb;
    localparam int H = 24;
    localparam int Q = 12;
    localparam int WRC = 600;
    localparam logic [7:0] DEVW = 8'hA4;
    localparam logic [7:0] DEVR = 8'hA5;
    localparam logic [15:0] VEC [6] = '{16'h035A, 16'h17C3, 16'h8800,
                                        16'h9FFF, 16'hB1A5, 16'hE63C};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic wp = 1'b0;
    logic pull;
    wire  sda_line = sda_m & ~pull;
    int   checks = 0;
    int   failures = 0;
    logic [7:0] rbuf [16];

    always #10 clk = ~clk;

    eeprom_2w_slave #(.WR_CYCLES(WRC)) u_dut (
        .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_line),
        .strap_addr(3'b010), .wr_protect(wp), .sda_pull_low(pull));

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic bus_start;
        sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b0; tick(H); scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b1; tick(H);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; tick(Q); scl = 1'b1; tick(H); scl = 1'b0; tick(Q);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q); b = sda_line; tick(Q); scl = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(b);
        ack = !b;
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic mack);
        for (int i = 7; i >= 0; i--) get_bit(d[i]);
        put_bit(!mack);
    endtask

    task automatic read_seq(input logic [7:0] a, input logic rnd, input int n);
        logic k;
        if (rnd) begin
            bus_start; send_byte(DEVW, k); send_byte(a, k);
        end
        bus_start; send_byte(DEVR, k);
        for (int i = 0; i < n; i++) recv_byte(rbuf[i], i < n - 1);
        bus_stop;
    endtask

    task automatic write_bytes(input logic [7:0] a, input logic [7:0] d0, input int n);
        logic k;
        bus_start; send_byte(DEVW, k); send_byte(a, k);
        for (int i = 0; i < n; i++) send_byte(d0 + 8'(i), k);
        bus_stop;
    endtask

    task automatic wait_ready;
        logic k;
        for (int i = 0; i < 40; i++) begin
            bus_start; send_byte(DEVW, k); bus_stop;
            if (k) break;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic k;
        tick(3);
        chk("R4 released in reset", pull, 1'b0);
        tick(3); rst = 1'b0; tick(10);
        chk("R4 released idle", pull, 1'b0);

        // R10: table of byte writes, each read back by a random read
        for (int i = 0; i < 6; i++) begin
            write_bytes(VEC[i][15:8], VEC[i][7:0], 1);
            wait_ready;
            read_seq(VEC[i][15:8], 1'b1, 1);
            chk("R10 random read", rbuf[0], VEC[i][7:0]);
        end

        // R1 / R2: address matching
        bus_start; send_byte(DEVW, k); bus_stop;
        chk("R1 matching device byte acked", k, 1'b1);
        bus_start; send_byte(8'hAA, k);
        chk("R2 wrong strap not acked", k, 1'b0);
        send_byte(8'h00, k);
        chk("R2 ignored after mismatch", k, 1'b0);
        bus_stop;
        bus_start; send_byte(8'hE4, k); bus_stop;
        chk("R1 wrong fixed pattern not acked", k, 1'b0);

        // R6: ten bytes from 0x45 wrap inside page 0x40
        write_bytes(8'h45, 8'h10, 10);
        // R7: polled right after STOP gives no acknowledge
        bus_start; send_byte(DEVW, k); bus_stop;
        chk("R7 no ack during timed cycle", k, 1'b0);
        wait_ready;
        bus_start; send_byte(DEVW, k); bus_stop;
        chk("R7 ack after timed cycle", k, 1'b1);
        read_seq(8'h40, 1'b1, 8);
        chk("R6 page 0x40", rbuf[0], 8'h13);
        chk("R6 page 0x43", rbuf[3], 8'h16);
        chk("R6 page 0x45 last wins", rbuf[5], 8'h18);
        chk("R6 page 0x46 last wins", rbuf[6], 8'h19);
        chk("R6 page 0x47", rbuf[7], 8'h12);

        // R9: current address read follows a random read
        read_seq(8'h40, 1'b1, 1);
        read_seq(8'h00, 1'b0, 1);
        chk("R9 current address read", rbuf[0], 8'h14);

        // R11: sequential read across 255 -> 0
        write_bytes(8'hFE, 8'hE1, 2); wait_ready;
        write_bytes(8'h00, 8'hE3, 2); wait_ready;
        read_seq(8'hFE, 1'b1, 4);
        chk("R11 seq 0xFE", rbuf[0], 8'hE1);
        chk("R11 seq 0xFF", rbuf[1], 8'hE2);
        chk("R11 seq wrap 0x00", rbuf[2], 8'hE3);
        chk("R11 seq 0x01", rbuf[3], 8'hE4);

        // R8: protected write leaves array and bus untouched
        wp = 1'b1;
        write_bytes(8'h03, 8'h99, 1);
        bus_start; send_byte(DEVW, k); bus_stop;
        chk("R8 no timed cycle when protected", k, 1'b1);
        wp = 1'b0;
        read_seq(8'h03, 1'b1, 1);
        chk("R8 protected byte unchanged", rbuf[0], 8'h5A);

        // R5: repeated START before STOP discards pending data
        bus_start; send_byte(DEVW, k); send_byte(8'h17, k); send_byte(8'h66, k);
        bus_start; bus_stop;
        bus_start; send_byte(DEVW, k); bus_stop;
        chk("R5 no timed cycle after abort", k, 1'b1);
        read_seq(8'h17, 1'b1, 1);
        chk("R5 aborted write not committed", rbuf[0], 8'hC3);

        tick(20);
        chk("R4 released at end", pull, 1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule